// File: doc/BRIEF.md
# Framed SPI Master Channel

This block is the master side of one SPI channel. It sends a word on the data output and, on the same clock edges, collects the word that the slave returns. The word length can be set from 1 to 16 bits, and the bits can go out least significant first or most significant first. Each transfer runs inside a select frame. The frame opens when the first word is accepted. It stays open while more words follow, and it closes when no further word is waiting.

Four timed intervals surround the shifting, and each is counted in ticks of an external time-quantum strobe. A leading interval runs between select going active and the first clock edge. A trailing interval runs between the last bit and select going inactive. An inter-word interval separates the words of one frame, and a next-frame interval keeps select inactive between two frames. Each interval is set by a small pre-divider and a divider, so its length is the product of the two. The leading and trailing intervals share one pair of settings, and the other two intervals share a second pair. A baud generator outside the block gives one shift-clock enable per half period of SCLK.

The frame select can be steered to any one of eight select outputs, with either active level. Outputs that are not selected stay at the inactive level.

Top module: `spi_frame_master`

## Requirements
- R1: `cfg_len_i` holds the word length minus one. A frame word shifts `cfg_len_i`+1 bits. In `rx_data_o`, bits `cfg_len_i`..0 hold the received bits and every bit above them is zero. Only bits `cfg_len_i`..0 of `tx_data_i` are sent.
- R2: With `cfg_msb_first_i`=1, bit `cfg_len_i` of the word is sent first and bit 0 last. With 0, bit 0 is sent first. The k-th received bit is stored at the same bit position as the k-th transmitted bit.
- R3: When `cfg_sel_high_i`=1 the active select level is 1. When it is 0 the active level is 0. Outside a frame, all eight select outputs sit at the inactive level.
- R4: During a frame, only `sel_o[cfg_sel_idx_i]` is active. The other seven stay inactive.
- R5: The leading interval is (`cfg_lt_pre_i`+1)*(`cfg_lt_div_i`+1) time-quantum ticks, counted from select going active. The first SCLK rising edge comes only after this interval, at the next two shift enables.
- R6: The trailing interval begins at the SCLK falling edge that ends the last word of a frame. Select goes inactive on exactly the (`cfg_lt_pre_i`+1)*(`cfg_lt_div_i`+1)-th tick after that edge.
- R7: If `tx_valid_i` is high when a word ends, that word is taken in the same frame and select stays active. Its first SCLK rising edge comes after (`cfg_wf_pre_i`+1)*(`cfg_wf_div_i`+1) ticks.
- R8: While no bit of a word is being driven, `mosi_o` equals `cfg_passive_i`. This covers idle time, every delay interval and the leading interval. The passive level holds until the first drive step of a word.
- R9: SCLK is low outside words. Each bit is driven on a low-going step and sampled from `miso_i` on the following SCLK rising edge. The word ends with one extra falling step.
- R10: `rx_valid_o` pulses high for exactly one cycle, with `rx_data_o` valid, in the cycle after the final falling step of every word.
- R11: `tx_ready_o` is high when the block is idle, and also in the cycle where a word ends. A word is accepted when `tx_valid_i` and `tx_ready_o` are both high. `busy_o` is high from the acceptance that opens a frame until the next-frame interval ends.
- R12: After select goes inactive, it stays inactive for at least (`cfg_wf_pre_i`+1)*(`cfg_wf_div_i`+1) ticks before the next frame opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_en_i | input | 1 | Shift enable, one per SCLK half period |
| tq_tick_i | input | 1 | Time-quantum tick for the delay intervals |
| cfg_len_i | input | 4 | Word length minus one |
| cfg_msb_first_i | input | 1 | 1: most significant bit first |
| cfg_sel_high_i | input | 1 | 1: select is active high |
| cfg_sel_idx_i | input | 3 | Index of the select output to drive |
| cfg_passive_i | input | 1 | Data output level while no bit is driven |
| cfg_lt_pre_i | input | 2 | Pre-divider for the leading and trailing intervals |
| cfg_lt_div_i | input | 5 | Divider for the leading and trailing intervals |
| cfg_wf_pre_i | input | 2 | Pre-divider for the inter-word and next-frame intervals |
| cfg_wf_div_i | input | 5 | Divider for the inter-word and next-frame intervals |
| tx_data_i | input | 16 | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit word can be taken this cycle |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Shift clock |
| mosi_o | output | 1 | Serial data to the slave |
| sel_o | output | 8 | Select outputs |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | Received word event |
| busy_o | output | 1 | A frame or its closing interval is in progress |

## Verification
The bench models the slave. It offers a known reply on every word and rebuilds the transmitted word from the data output at each SCLK rise, so a wrong bit index or bit order shows up as a mismatched word at 1, 8 and 16 bits. It counts time-quantum ticks across each of the four intervals. A design that shared the wrong prescaler pair, or that took the next word without the inter-word wait, would show a count outside its window. Back-to-back frames and frames of several words test the two cases a faulty block mixes up: closing the frame when a word was still pending, and dropping select too early between frames. The bench also checks the passive level at the start of every frame and the level of every select line, with both select polarities and with indices 0 and 7.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP,
    ST_TRAIL,
    ST_NEXT
  } frame_state_e;
endpackage

// File: rtl/spi_tq_delay.sv
module spi_tq_delay #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             done_o
);
  localparam int CNT_W = PRE_W + DIV_W + 1;

  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign total  = (CNT_W'(pre_i) + CNT_W'(1)) * (CNT_W'(div_i) + CNT_W'(1));
  assign done_o = run_q && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= total;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              msb_first_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_bit_o,
  output logic              drive_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [CNT_W-1:0]  nbits;
  logic [LEN_W-1:0]  idx;
  logic              phase_q;

  assign nbits  = {1'b0, len_i} + CNT_W'(1);
  // msb first walks the index down from len
  assign idx    = msb_first_i ? (len_i - bcnt_q[LEN_W-1:0]) : bcnt_q[LEN_W-1:0];
  assign done_o = step_i && !phase_q && (bcnt_q == nbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      rx_q       <= '0;
      bcnt_q     <= '0;
      phase_q    <= 1'b0;
      sclk_o     <= 1'b0;
      mosi_bit_o <= 1'b0;
      drive_o    <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= done_o;
      if (done_o) rx_data_o <= rx_q;
      if (load_i) begin
        tx_q    <= load_data_i;
        rx_q    <= '0;
        bcnt_q  <= '0;
        phase_q <= 1'b0;
        sclk_o  <= 1'b0;
        drive_o <= 1'b0;
      end else if (step_i) begin
        if (!phase_q) begin
          sclk_o <= 1'b0;
          if (bcnt_q == nbits) begin
            drive_o <= 1'b0;
          end else begin
            mosi_bit_o <= tx_q[idx];
            drive_o    <= 1'b1;
            phase_q    <= 1'b1;
          end
        end else begin
          sclk_o    <= 1'b1;
          rx_q[idx] <= miso_i;
          bcnt_q    <= bcnt_q + CNT_W'(1);
          phase_q   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_sel_route.sv
module spi_sel_route #(
  parameter int NSEL  = 8,
  parameter int SEL_W = 3
) (
  input  logic             frame_act_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic             act_high_i,
  output logic [NSEL-1:0]  sel_o
);
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel_o[g] = (frame_act_i && (idx_i == SEL_W'(g))) ? act_high_i : ~act_high_i;
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DATA_W = 16,
  parameter int NSEL   = 8,
  parameter int PRE_W  = 2,
  parameter int DIV_W  = 5,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int SEL_W = $clog2(NSEL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_en_i,
  input  logic              tq_tick_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_msb_first_i,
  input  logic              cfg_sel_high_i,
  input  logic [SEL_W-1:0]  cfg_sel_idx_i,
  input  logic              cfg_passive_i,
  input  logic [PRE_W-1:0]  cfg_lt_pre_i,
  input  logic [DIV_W-1:0]  cfg_lt_div_i,
  input  logic [PRE_W-1:0]  cfg_wf_pre_i,
  input  logic [DIV_W-1:0]  cfg_wf_div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NSEL-1:0]   sel_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o
);
  import spi_frame_pkg::*;

  frame_state_e state_q, state_d;
  logic frame_act_q;
  logic word_done, step, load;
  logic lt_start, lt_done, wf_start, wf_done;
  logic mosi_bit, drive;

  assign step       = (state_q == ST_SHIFT) && sclk_en_i;
  assign tx_ready_o = (state_q == ST_IDLE) || word_done;
  assign load       = tx_valid_i && tx_ready_o;
  assign busy_o     = (state_q != ST_IDLE);
  assign mosi_o     = drive ? mosi_bit : cfg_passive_i;

  assign lt_start = ((state_q == ST_IDLE) && tx_valid_i) ||
                    (word_done && !tx_valid_i);
  assign wf_start = (word_done && tx_valid_i) ||
                    ((state_q == ST_TRAIL) && lt_done);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (tx_valid_i) state_d = ST_LEAD;
      ST_LEAD:  if (lt_done)    state_d = ST_SHIFT;
      ST_SHIFT: if (word_done)  state_d = tx_valid_i ? ST_GAP : ST_TRAIL;
      ST_GAP:   if (wf_done)    state_d = ST_SHIFT;
      ST_TRAIL: if (lt_done)    state_d = ST_NEXT;
      ST_NEXT:  if (wf_done)    state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      frame_act_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE) && tx_valid_i)   frame_act_q <= 1'b1;
      else if ((state_q == ST_TRAIL) && lt_done) frame_act_q <= 1'b0;
    end
  end

  spi_tq_delay #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_lt_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lt_start),
    .tick_i  (tq_tick_i),
    .pre_i   (cfg_lt_pre_i),
    .div_i   (cfg_lt_div_i),
    .done_o  (lt_done)
  );

  spi_tq_delay #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_wf_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wf_start),
    .tick_i  (tq_tick_i),
    .pre_i   (cfg_wf_pre_i),
    .div_i   (cfg_wf_div_i),
    .done_o  (wf_done)
  );

  spi_word_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .step_i      (step),
    .len_i       (cfg_len_i),
    .msb_first_i (cfg_msb_first_i),
    .miso_i      (miso_i),
    .sclk_o      (sclk_o),
    .mosi_bit_o  (mosi_bit),
    .drive_o     (drive),
    .done_o      (word_done),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o)
  );

  spi_sel_route #(.NSEL(NSEL), .SEL_W(SEL_W)) u_sel (
    .frame_act_i (frame_act_q),
    .idx_i       (cfg_sel_idx_i),
    .act_high_i  (cfg_sel_high_i),
    .sel_o       (sel_o)
  );
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
  parameter int NSEL = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_sel_high_i,
  input logic            cfg_passive_i,
  input logic            tx_valid_i,
  input logic            tx_ready_o,
  input logic            sclk_o,
  input logic            mosi_o,
  input logic [NSEL-1:0] sel_o,
  input logic            rx_valid_o,
  input logic            busy_o
);
  logic [NSEL-1:0] act_bits;
  assign act_bits = sel_o ^ {NSEL{~cfg_sel_high_i}};

  p_one_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_bits) <= 1);

  p_idle_sclk_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  p_idle_passive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mosi_o == cfg_passive_i));

  p_rx_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o && !busy_o) |=> busy_o);

  p_sclk_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (act_bits != '0));
endmodule

bind spi_frame_master spi_frame_master_chk #(.NSEL(NSEL)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_sel_high_i (cfg_sel_high_i),
  .cfg_passive_i  (cfg_passive_i),
  .tx_valid_i     (tx_valid_i),
  .tx_ready_o     (tx_ready_o),
  .sclk_o         (sclk_o),
  .mosi_o         (mosi_o),
  .sel_o          (sel_o),
  .rx_valid_o     (rx_valid_o),
  .busy_o         (busy_o)
);

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int NSEL   = 8;
  localparam int TQP    = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_en = 1'b0, tq_tick = 1'b0;
  logic [3:0] len = 4'd7;
  logic msb = 1'b0, sel_high = 1'b0, passive = 1'b1;
  logic [2:0] sel_idx = 3'd0;
  logic [1:0] lt_pre = 2'd0, wf_pre = 2'd0;
  logic [4:0] lt_div = 5'd4, wf_div = 5'd0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_valid = 1'b0, miso = 1'b0;
  logic tx_ready, sclk, mosi, rx_valid, busy;
  logic [NSEL-1:0] sel;
  logic [DATA_W-1:0] rx_data;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] tx_q [0:255];
  logic [DATA_W-1:0] sw_q [0:255];
  int wr = 0, rd = 0;
  bit mon_en = 0;

  spi_frame_master uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_en_i(sclk_en), .tq_tick_i(tq_tick),
    .cfg_len_i(len), .cfg_msb_first_i(msb), .cfg_sel_high_i(sel_high),
    .cfg_sel_idx_i(sel_idx), .cfg_passive_i(passive),
    .cfg_lt_pre_i(lt_pre), .cfg_lt_div_i(lt_div),
    .cfg_wf_pre_i(wf_pre), .cfg_wf_div_i(wf_div),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .sel_o(sel),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    sclk_en = (cyc % 2 == 0);
    tq_tick = (cyc % TQP == 0);
  end

  function automatic logic [DATA_W-1:0] mask_of(input logic [3:0] l);
    return (l == 4'd15) ? 16'hFFFF : ((16'h1 << (int'(l) + 1)) - 16'h1);
  endfunction
  function automatic int bit_pos(input logic [3:0] l, input logic m, input int r);
    return m ? (int'(l) - r) : r;
  endfunction
  function automatic int span(input logic [1:0] p, input logic [4:0] d);
    return (int'(p) + 1) * (int'(d) + 1);
  endfunction
  function automatic logic [NSEL-1:0] sel_vec(input bit on);
    logic [NSEL-1:0] v;
    v = {NSEL{~sel_high}};
    if (on) v[sel_idx] = sel_high;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave model and monitor
  bit prev_sclk = 0, prev_act = 0, prev_busy = 0, seen_rise = 0, in_iw = 0, have_prev = 0;
  int lead_cnt = 0, iw_cnt = 0, trail_cnt = 0, gap_cnt = 0, gap_need = 0, rises = 0;
  logic [DATA_W-1:0] got_tx = '0;

  always @(negedge clk) begin
    #2;
    if (mon_en) begin
      automatic bit act  = (sel[sel_idx] == sel_high);
      automatic bit rise = sclk && !prev_sclk;
      automatic bit fall = !sclk && prev_sclk;
      automatic int nb   = int'(len) + 1;
      automatic logic [DATA_W-1:0] m = mask_of(len);
      if (act && !prev_act) begin
        chk(sel == sel_vec(1), "R4", "select vector at frame open", sel, sel_vec(1));
        chk(mosi == passive, "R8", "mosi at frame open", mosi, passive);
        chk(busy, "R11", "busy in frame", busy, 1);
        if (have_prev) chk(gap_cnt >= gap_need, "R12", "next-frame ticks", gap_cnt, gap_need);
        lead_cnt = 0; seen_rise = 0; in_iw = 0; rises = 0; got_tx = '0;
      end
      if (!act && prev_act) begin
        chk(trail_cnt == span(lt_pre, lt_div), "R6", "trailing ticks", trail_cnt, span(lt_pre, lt_div));
        chk(sel == sel_vec(0), "R3", "select vector after close", sel, sel_vec(0));
        gap_cnt = 0; gap_need = span(wf_pre, wf_div); have_prev = 1;
      end
      if (!busy && prev_busy) begin
        chk(!sclk && mosi == passive, "R9", "idle sclk/mosi", {sclk, mosi}, {1'b0, passive});
        chk(tx_ready, "R11", "ready when idle", tx_ready, 1);
      end
      if (rise) begin
        if (!seen_rise)
          chk(lead_cnt >= span(lt_pre, lt_div) && lead_cnt <= span(lt_pre, lt_div) + 1,
              "R5", "leading ticks", lead_cnt, span(lt_pre, lt_div));
        if (in_iw)
          chk(iw_cnt >= span(wf_pre, wf_div) && iw_cnt <= span(wf_pre, wf_div) + 1,
              "R7", "inter-word ticks", iw_cnt, span(wf_pre, wf_div));
        in_iw = 0; seen_rise = 1;
        got_tx[bit_pos(len, msb, rises)] = mosi;
        rises++;
      end
      if (fall && rises == nb) begin
        chk(rx_valid, "R10", "rx event at word end", rx_valid, 1);
        chk(rx_data == (sw_q[rd] & m), "R1", "received word", rx_data, sw_q[rd] & m);
        chk(got_tx == (tx_q[rd] & m), "R2", "transmitted word", got_tx, tx_q[rd] & m);
        chk(act, "R7", "select held at word end", act, 1);
        rd++; rises = 0; got_tx = '0; trail_cnt = 0; iw_cnt = 0; in_iw = 1;
      end else if (rx_valid) begin
        chk(0, "R10", "stray rx event", 1, 0);
      end
      if (tq_tick) begin
        if (act && !seen_rise) lead_cnt++;
        if (in_iw) iw_cnt++;
        if (act) trail_cnt++;
        else gap_cnt++;
      end
      miso = (rises < nb) ? sw_q[rd][bit_pos(len, msb, rises)] : 1'b0;
      prev_sclk = sclk; prev_act = act; prev_busy = busy;
    end
  end

  task automatic send_frame(input int nw, input bit wait_idle);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      tx_data = DATA_W'($urandom);
      tx_q[wr] = tx_data;
      sw_q[wr] = DATA_W'($urandom);
      tx_valid = 1'b1;
      #1;
      while (!tx_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      wr++;
    end
    tx_valid = 1'b0;
    if (wait_idle) begin
      @(negedge clk); #3;
      while (busy) begin @(negedge clk); #3; end
    end else begin
      @(negedge clk); #3;
      while (sel[sel_idx] == sel_high) begin @(negedge clk); #3; end
    end
  endtask

  task automatic set_cfg(input logic [3:0] l, input logic mf, input logic sh,
                         input logic [2:0] si, input logic pv,
                         input logic [1:0] lp, input logic [4:0] ld,
                         input logic [1:0] wp, input logic [4:0] wd);
    @(negedge clk);
    len = l; msb = mf; sel_high = sh; sel_idx = si; passive = pv;
    lt_pre = lp; lt_div = ld; wf_pre = wp; wf_div = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(sel == sel_vec(0), "R3", "reset select vector", sel, sel_vec(0));
    chk(!sclk && mosi == passive, "R9", "reset sclk/mosi", {sclk, mosi}, {1'b0, passive});
    chk(!busy && !rx_valid && tx_ready, "R11", "reset busy/rx/ready",
        {busy, rx_valid, tx_ready}, 3'b001);
    mon_en = 1;
    // R1/R2 8-bit lsb-first single word, active-low on line 0
    set_cfg(4'd7, 1'b0, 1'b0, 3'd0, 1'b1, 2'd0, 5'd4, 2'd0, 5'd0);
    send_frame(1, 1);
    // 16-bit msb-first, active high on line 7, three-word frame
    set_cfg(4'd15, 1'b1, 1'b1, 3'd7, 1'b0, 2'd1, 5'd2, 2'd1, 5'd1);
    send_frame(3, 1);
    // single-bit words
    set_cfg(4'd0, 1'b1, 1'b0, 3'd3, 1'b1, 2'd0, 5'd0, 2'd0, 5'd0);
    send_frame(2, 1);
    // back-to-back frames with a long next-frame interval (R12)
    set_cfg(4'd4, 1'b0, 1'b1, 3'd5, 1'b0, 2'd2, 5'd1, 2'd3, 5'd2);
    send_frame(2, 0);
    send_frame(2, 1);
    // random mix
    for (int f = 0; f < 20; f++) begin
      set_cfg(4'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
              2'($urandom), 5'($urandom_range(0, 7)), 2'($urandom), 5'($urandom_range(0, 7)));
      send_frame($urandom_range(1, 3), 1'($urandom));
    end
    @(negedge clk); #3;
    while (busy) begin @(negedge clk); #3; end
    repeat (4) @(negedge clk);
    chk(rd == wr, "R10", "all words received", rd, wr);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule